// File: doc/BRIEF.md
# Multi-dimensional DMA address generator

This block walks the word addresses of a single DMA transfer. A transfer is described by a descriptor that holds a base address, four nested dimensions (each with a size and a stride), an iteration count and an iteration offset. Dimension 0 changes fastest. The iteration level wraps the whole four-level walk, and each repetition adds the offset to the base, so the walk behaves like a five-level one.

Descriptors are written into an internal table of 48 entries. A start pulse names one entry and a direction. In the read direction (memory to stream), each of the three inner dimensions may add leading and trailing pad positions. These come out as zero-fill beats rather than memory addresses. In the write direction (stream to memory), the pad counts are ignored. Beats leave on a valid/ready stream, and a one-cycle done pulse closes the transfer.

Top module: `dma_addr_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `valid_o` and `done_o` are 0.
- R2: Beats are produced with dimension 0 advancing fastest. A non-pad beat carries base + sum over d of (counter_d − pre_d)·stride_d + iteration·offset, modulo 2^ADDR_W. Here pre_d is the leading pad count in force, and the dimension 3 counter has no pad.
- R3: The full four-level walk is repeated iter_cnt+1 times, where `iter_cnt` is the 6-bit descriptor field. The iteration index starts at 0.
- R4: With `dir_i`=1 (read), dimension d∈{0,1,2} spans pre_d+size_d+post_d positions. Positions below pre_d or at/after pre_d+size_d give `pad_o`=1 and `addr_o`=0. A pad position adds no stride.
- R5: With `dir_i`=0 (write), pad counts are ignored: no beat has `pad_o`=1, and each dimension spans exactly size_d positions.
- R6: If any of the four sizes is 0, the transfer makes no beat and `done_o` is 1 in the cycle after the start edge.
- R7: `done_o` is 1 for exactly one cycle, in the cycle after the last beat is accepted, and is never 1 together with `valid_o`.
- R8: While `valid_o`=1 and `ready_i`=0, `valid_o`, `addr_o` and `pad_o` hold their values into the next cycle.
- R9: A descriptor written at index k (0..47) through the write port is used by a later start with `bd_sel_i`=k. The first beat appears in the cycle after the start edge.
- R10: A start pulse given while a transfer is running or finishing is ignored, and the running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bd_we_i | input | 1 | Descriptor table write enable |
| bd_waddr_i | input | 6 | Descriptor table write index |
| bd_wdata_i | input | 158 | Packed descriptor (`bd_t`) |
| start_i | input | 1 | Start a transfer when idle |
| bd_sel_i | input | 6 | Descriptor index for the transfer |
| dir_i | input | 1 | 1 = memory to stream (padding on), 0 = stream to memory |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | Beat valid |
| ready_i | input | 1 | Beat accepted by the consumer |
| addr_o | output | 16 | Word address, 0 on pad beats |
| pad_o | output | 1 | Zero-fill beat marker |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit sizes, 4-bit pad counts, a 6-bit iteration count and 48 descriptors. With these values the last table index (47) can be used, address wrap-around at 2^16 can be reached through both stride and iteration offset, and pad regions in all three inner dimensions fit in short transfers. A behavioural model expands each descriptor into a queue of expected beats. The bench compares every cycle while the ready line follows both a constant pattern and a pseudo-random one, which exercises stalls at arbitrary points of the walk.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;
  parameter int ADDR_W      = 16;
  parameter int SIZE_W      = 8;
  parameter int PAD_W       = 4;
  parameter int ITER_W      = 6;
  parameter int NUM_DIM     = 4;
  parameter int NUM_PAD_DIM = 3;
  localparam int CNT_W      = SIZE_W + 2;

  typedef struct packed {
    logic [ITER_W-1:0]                       iter_cnt;
    logic [ADDR_W-1:0]                       iter_off;
    logic [NUM_PAD_DIM-1:0][PAD_W-1:0]       pad_post;
    logic [NUM_PAD_DIM-1:0][PAD_W-1:0]       pad_pre;
    logic [NUM_DIM-1:0][ADDR_W-1:0]          stride;
    logic [NUM_DIM-1:0][SIZE_W-1:0]          size;
    logic [ADDR_W-1:0]                       base;
  } bd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/dma_bd_table.sv
module dma_bd_table
  import dma_walk_pkg::*;
#(
  parameter int NUM_BD = 48,
  localparam int IDX_W = $clog2(NUM_BD)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  bd_t              wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output bd_t              rdata_o
);
  bd_t mem_q [NUM_BD];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < NUM_BD)) mem_q[waddr_i] <= wdata_i;
  end

  // out-of-range index reads as an empty descriptor
  always_comb begin
    rdata_o = '0;
    if (32'(raddr_i) < NUM_BD) rdata_o = mem_q[raddr_i];
  end
endmodule

// File: rtl/dma_dim_counter.sv
module dma_dim_counter
  import dma_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [PAD_W-1:0]  pre_i,
  input  logic [PAD_W-1:0]  post_i,
  output logic              last_o,
  output logic              pad_o,
  output logic [ADDR_W-1:0] part_o
);
  logic [CNT_W-1:0] cnt_q, pre_w, data_end_w, len_w;

  assign pre_w      = CNT_W'(pre_i);
  assign data_end_w = pre_w + CNT_W'(size_i);
  assign len_w      = data_end_w + CNT_W'(post_i);
  assign last_o     = (cnt_q == len_w - CNT_W'(1));
  assign pad_o      = (cnt_q < pre_w) || (cnt_q >= data_end_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      part_o <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      part_o <= '0;
    end else if (step_i) begin
      if (last_o) begin
        cnt_q  <= '0;
        part_o <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        // leading pad leaves the offset at zero
        if (cnt_q >= pre_w) part_o <= part_o + stride_i;
      end
    end
  end
endmodule

// File: rtl/dma_walk_ctrl.sv
module dma_walk_ctrl
  import dma_walk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              zero_i,
  input  logic              fire_i,
  input  logic              walk_last_i,
  input  logic [ITER_W-1:0] iter_cnt_i,
  input  logic [ADDR_W-1:0] iter_off_i,
  output logic              accept_o,
  output logic              run_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] iter_part_o
);
  walk_state_e       state_q;
  logic [ITER_W-1:0] iter_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign run_o    = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      iter_q      <= '0;
      iter_part_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q     <= zero_i ? ST_DONE : ST_RUN;
          iter_q      <= '0;
          iter_part_o <= '0;
        end
        ST_RUN: if (fire_i && walk_last_i) begin
          if (iter_q == iter_cnt_i) begin
            state_q <= ST_DONE;
          end else begin
            iter_q      <= iter_q + ITER_W'(1);
            iter_part_o <= iter_part_o + iter_off_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_addr_walker.sv
module dma_addr_walker
  import dma_walk_pkg::*;
#(
  parameter int NUM_BD  = 48,
  localparam int IDX_W  = $clog2(NUM_BD),
  localparam int BD_W   = $bits(bd_t)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bd_we_i,
  input  logic [IDX_W-1:0]  bd_waddr_i,
  input  logic [BD_W-1:0]   bd_wdata_i,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  bd_sel_i,
  input  logic              dir_i,
  output logic              done_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pad_o
);
  bd_t                            rd_bd, cur_bd_q;
  logic                           mm2s_q;
  logic                           accept, fire, zero_size;
  logic [NUM_DIM-1:0]             last_w, pad_w, step_w;
  logic [NUM_DIM-1:0][ADDR_W-1:0] part_w;
  logic [ADDR_W-1:0]              iter_part, sum_w;

  dma_bd_table #(.NUM_BD(NUM_BD)) u_table (
    .clk_i   (clk_i),
    .we_i    (bd_we_i),
    .waddr_i (bd_waddr_i),
    .wdata_i (bd_t'(bd_wdata_i)),
    .raddr_i (bd_sel_i),
    .rdata_o (rd_bd)
  );

  always_comb begin
    zero_size = 1'b0;
    for (int d = 0; d < NUM_DIM; d++) zero_size |= (rd_bd.size[d] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_bd_q <= '0;
      mm2s_q   <= 1'b0;
    end else if (accept) begin
      cur_bd_q <= rd_bd;
      mm2s_q   <= dir_i;
    end
  end

  dma_walk_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .zero_i      (zero_size),
    .fire_i      (fire),
    .walk_last_i (&last_w),
    .iter_cnt_i  (cur_bd_q.iter_cnt),
    .iter_off_i  (cur_bd_q.iter_off),
    .accept_o    (accept),
    .run_o       (valid_o),
    .done_o      (done_o),
    .iter_part_o (iter_part)
  );

  assign fire = valid_o && ready_i;

  for (genvar d = 0; d < NUM_DIM; d++) begin : g_dim
    logic [PAD_W-1:0] pre_eff, post_eff;
    if (d < NUM_PAD_DIM) begin : g_pad
      assign pre_eff  = mm2s_q ? cur_bd_q.pad_pre[d]  : '0;
      assign post_eff = mm2s_q ? cur_bd_q.pad_post[d] : '0;
    end else begin : g_nopad
      assign pre_eff  = '0;
      assign post_eff = '0;
    end

    if (d == 0) begin : g_step0
      assign step_w[d] = fire;
    end else begin : g_stepn
      assign step_w[d] = step_w[d-1] && last_w[d-1];
    end

    dma_dim_counter u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (accept),
      .step_i   (step_w[d]),
      .size_i   (cur_bd_q.size[d]),
      .stride_i (cur_bd_q.stride[d]),
      .pre_i    (pre_eff),
      .post_i   (post_eff),
      .last_o   (last_w[d]),
      .pad_o    (pad_w[d]),
      .part_o   (part_w[d])
    );
  end

  always_comb begin
    sum_w = cur_bd_q.base + iter_part;
    for (int d = 0; d < NUM_DIM; d++) sum_w = sum_w + part_w[d];
  end

  // dimension 3 never pads, so its flag is left out
  assign pad_o  = |pad_w[NUM_PAD_DIM-1:0];
  assign addr_o = pad_o ? '0 : sum_w;
endmodule

// File: rtl/dma_walk_chk.sv
module dma_walk_chk
  import dma_walk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              valid_o,
  input logic              ready_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              pad_o,
  input logic              done_o,
  input logic              mm2s_q
);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(pad_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

  p_done_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_o && ready_i) || $past(start_i));

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && pad_o |-> addr_o == '0);

  p_no_pad_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !mm2s_q |-> !pad_o);
endmodule

bind dma_addr_walker dma_walk_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .valid_o (valid_o),
  .ready_i (ready_i),
  .addr_o  (addr_o),
  .pad_o   (pad_o),
  .done_o  (done_o),
  .mm2s_q  (mm2s_q)
);

// File: tb/tb_dma_addr_walker.sv
`timescale 1ns/1ps
module tb_dma_addr_walker;
  import dma_walk_pkg::*;

  localparam int NUM_BD = 48;
  localparam int IDX_W  = $clog2(NUM_BD);
  localparam int BD_W   = $bits(bd_t);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bd_we_i = 1'b0;
  logic [IDX_W-1:0]  bd_waddr_i = '0;
  logic [BD_W-1:0]   bd_wdata_i = '0;
  logic              start_i = 1'b0;
  logic [IDX_W-1:0]  bd_sel_i = '0;
  logic              dir_i = 1'b0;
  logic              done_o, valid_o, pad_o;
  logic              ready_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;

  always #2.5 clk_i = ~clk_i;

  dma_addr_walker #(.NUM_BD(NUM_BD)) dut (.*);

  int   total = 0, bad = 0;
  bd_t  tbl [NUM_BD];
  int   exp_a[$];
  bit   exp_p[$];
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(bit ok, string tag, int ea, bit ep);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: valid=%b done=%b addr=%h pad=%b exp addr=%h pad=%b",
               tag, valid_o, done_o, addr_o, pad_o, ea[15:0], ep);
    end
  endtask

  task automatic wr_bd(int idx, bd_t b);
    tbl[idx] = b;
    @(negedge clk_i);
    bd_we_i = 1'b1; bd_waddr_i = IDX_W'(idx); bd_wdata_i = b;
    @(negedge clk_i);
    bd_we_i = 1'b0;
  endtask

  // behavioural expansion of a descriptor into beats
  function automatic void gen(bd_t b, bit mm2s);
    int p[3], t[3], s[3];
    exp_a.delete(); exp_p.delete();
    for (int d = 0; d < 4; d++) if (b.size[d] == 0) return;
    for (int d = 0; d < 3; d++) begin
      p[d] = mm2s ? int'(b.pad_pre[d]) : 0;
      s[d] = int'(b.size[d]);
      t[d] = p[d] + s[d] + (mm2s ? int'(b.pad_post[d]) : 0);
    end
    for (int it = 0; it <= int'(b.iter_cnt); it++)
      for (int c3 = 0; c3 < int'(b.size[3]); c3++)
        for (int c2 = 0; c2 < t[2]; c2++)
          for (int c1 = 0; c1 < t[1]; c1++)
            for (int c0 = 0; c0 < t[0]; c0++) begin
              bit pd = (c0 < p[0]) || (c0 >= p[0]+s[0]) ||
                       (c1 < p[1]) || (c1 >= p[1]+s[1]) ||
                       (c2 < p[2]) || (c2 >= p[2]+s[2]);
              int a = int'(b.base) + it*int'(b.iter_off) +
                      (c0-p[0])*int'(b.stride[0]) + (c1-p[1])*int'(b.stride[1]) +
                      (c2-p[2])*int'(b.stride[2]) + c3*int'(b.stride[3]);
              exp_a.push_back(pd ? 0 : (a & 32'hFFFF));
              exp_p.push_back(pd);
            end
  endfunction

  task automatic run(int idx, bit mm2s, string tag, bit rnd, bit poke);
    bit stalled = 0;
    int n = 0;
    gen(tbl[idx], mm2s);
    @(negedge clk_i);
    start_i = 1'b1; bd_sel_i = IDX_W'(idx); dir_i = mm2s;
    @(negedge clk_i);
    start_i = 1'b0;
    while (exp_a.size() > 0) begin
      bit rdy = rnd ? lfsr[0] : 1'b1;
      lfsr = {lfsr[6:0], lfsr[7]^lfsr[5]^lfsr[4]^lfsr[3]};
      ready_i = rdy;
      // R10: start during a running transfer must be ignored
      if (poke && n == 3) begin start_i = 1'b1; bd_sel_i = '0; dir_i = ~mm2s; end
      else start_i = 1'b0;
      chk(valid_o === 1'b1 && done_o === 1'b0 && addr_o === exp_a[0][15:0] &&
          pad_o === exp_p[0], stalled ? "R8" : (poke && n > 3) ? "R10" : tag,
          exp_a[0], exp_p[0]);
      @(posedge clk_i);
      if (rdy) begin void'(exp_a.pop_front()); void'(exp_p.pop_front()); end
      stalled = !rdy;
      n++;
      @(negedge clk_i);
    end
    start_i = 1'b0; ready_i = 1'b0;
    chk(done_o === 1'b1 && valid_o === 1'b0, (n == 0) ? "R6" : "R7", 0, 0);
    @(negedge clk_i);
    chk(done_o === 1'b0 && valid_o === 1'b0, "R7", 0, 0);
  endtask

  initial begin
    bit wd = 0;
    fork
      begin
        bd_t b;
        #1;
        chk(valid_o === 1'b0 && done_o === 1'b0, "R1", 0, 0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(valid_o === 1'b0 && done_o === 1'b0, "R1", 0, 0);

        // R2: plain 4-level walk, descriptor 0
        b = '0; b.base = 16'h0100;
        b.size[0] = 3; b.size[1] = 2; b.size[2] = 2; b.size[3] = 1;
        b.stride[0] = 1; b.stride[1] = 8; b.stride[2] = 32; b.stride[3] = 100;
        wr_bd(0, b);
        run(0, 1'b1, "R2", 1'b0, 1'b0);

        // R4 R3 R9: padding on three dims, two iterations, last index
        b = '0; b.base = 16'h0200;
        b.size[0] = 2; b.size[1] = 2; b.size[2] = 1; b.size[3] = 2;
        b.stride[0] = 2; b.stride[1] = 16; b.stride[2] = 64; b.stride[3] = 512;
        b.pad_pre[0] = 1; b.pad_post[0] = 2;
        b.pad_post[1] = 1;
        b.pad_pre[2] = 1;
        b.iter_cnt = 1; b.iter_off = 16'h1000;
        wr_bd(47, b);
        run(47, 1'b1, "R4", 1'b1, 1'b0);

        // R5: same descriptor, write direction ignores pads
        run(47, 1'b0, "R5", 1'b1, 1'b0);

        // R6: zero size in dimension 2
        b = tbl[0]; b.size[2] = 0;
        wr_bd(5, b);
        run(5, 1'b1, "R6", 1'b0, 1'b0);

        // R3 R10: address wrap through stride and iteration offset
        b = '0; b.base = 16'hFFF0;
        b.size[0] = 4; b.size[1] = 1; b.size[2] = 1; b.size[3] = 1;
        b.stride[0] = 16'h0010; b.iter_cnt = 2; b.iter_off = 16'h8000;
        wr_bd(9, b);
        run(9, 1'b1, "R3", 1'b1, 1'b1);

        // R9: descriptor 0 still intact after other writes
        run(0, 1'b0, "R9", 1'b1, 1'b0);
      end
      begin
        repeat (20000) @(posedge clk_i);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule